// File: doc/BRIEF.md
# Serial NOR Flash Command Front-End

This block is the serial side of a behavioural SPI NOR flash model. It watches chip select, serial clock and the serial input, assembles the opcode and any address, dummy or data bytes, and drives the serial output for the read-type commands. Read data is fetched from a backing byte array through a simple address/data port. The status byte and a busy flag come from a separate write controller. Every finished transaction is reported back to that controller as a one-cycle record.

The serial pins are sampled on a system clock that runs at least four times faster than the serial clock, and the pins are synchronous to it. A per-opcode framing table sets how many header bytes come before the output or data phase. It also sets how many bytes a write-type command must carry, and whether that count must be met exactly. The record then tells the write controller whether the frame was valid, including whether chip select rose on a byte boundary.

Top module: `flash_cmd_frontend`

## Requirements
- R1: Serial input is shifted in most-significant bit first, one bit on each rising serial clock edge while chip select is low. The serial output changes only after a falling serial clock edge. Both clock idle levels work (low idle, mode 0, and high idle, mode 3).
- R2: When chip select rises after at least one full byte, `cmd_valid` pulses for one cycle. With it come the first byte as `cmd_op` and bytes 2 to 4 as `cmd_addr` (byte 2 in bits 23:16). `cmd_aligned` is 1 only when the number of rising clock edges was a multiple of eight.
- R3: `cmd_ok` marks a valid frame. Write-type commands need `cmd_aligned`. 06h, 04h, C7h and 60h need exactly 1 byte. 20h and D8h need exactly 4 bytes. 01h needs exactly 2 bytes. 02h needs at least 5 bytes. Any opcode not named in R2 to R8 or R11 gives `cmd_ok` = 0.
- R4: After opcode 03h and three address bytes, the output streams the array byte at the address, then at each next address. `rd_addr` uses only the low ADDR_W address bits and wraps from all-ones to zero.
- R5: Opcode 0Bh takes three address bytes and one ignored dummy byte, then streams as in R4.
- R6: Opcode 05h streams the `status` input byte again and again, including while `busy` is high.
- R7: Opcode 9Fh streams 0Eh, 40h, 13h and then repeats that sequence.
- R8: Opcode 90h takes three address bytes, then alternates 0Eh and 12h. When address bit 0 is 1, 12h comes first.
- R9: If `busy` is high when the opcode byte of 03h, 0Bh or 9Fh completes, `so_oe` stays low for the whole transaction.
- R10: `so_oe` is low while chip select is high and during the opcode, address and dummy bytes. It goes high at the first falling edge after the last header byte.
- R11: For 01h and 02h, every full byte after the header gives a one-cycle `din_valid` pulse carrying that byte on `din_byte`.
- R12: A read-type command may end on any bit: once its header is complete, `cmd_ok` is 1 even when it is not aligned. The next transaction starts from a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| busy | input | 1 | Write controller cycle in progress |
| status | input | 8 | Status byte to return for 05h |
| rd_addr | output | ADDR_W | Array read address |
| rd_req | output | 1 | Pulse when an array byte is taken |
| rd_data | input | 8 | Array byte at rd_addr, combinational |
| cmd_valid | output | 1 | Transaction record strobe |
| cmd_op | output | 8 | Opcode of the record |
| cmd_addr | output | 24 | Address bytes of the record |
| cmd_aligned | output | 1 | Chip select rose on a byte boundary |
| cmd_ok | output | 1 | Frame is valid for its opcode |
| din_valid | output | 1 | Write data byte strobe |
| din_byte | output | 8 | Write data byte |

## Verification
The bench targets the framing edges. These are: a write-type opcode followed by three stray bits, an erase with one address byte short or one byte extra, a page program that has only its header, and a read cut off mid-bit. A front end that counts only bytes would accept the stray bits. One that ignores the exact-length rule would pass the long erase. Another corner is the address wrap at the top of the array and the 90h start with address bit 0 set. A wrong design there would either run past the array or return the manufacturer byte first. Busy-time reads are checked as well: a design that gates the wrong opcodes would either drive the output during a write cycle or go silent on status reads. Every read pattern is run in both clock idle levels, so an off-by-one between the falling and rising edges shows up as shifted data.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  typedef enum logic [3:0] {
    FK_UNKNOWN, FK_CTRL, FK_ERASE, FK_WSTAT, FK_PROG,
    FK_READ, FK_FREAD, FK_RSTAT, FK_IDENT, FK_MDID
  } fkind_e;

  function automatic fkind_e kind_of(input logic [7:0] op);
    case (op)
      8'h06, 8'h04, 8'hC7, 8'h60: kind_of = FK_CTRL;
      8'h20, 8'hD8:               kind_of = FK_ERASE;
      8'h01:                      kind_of = FK_WSTAT;
      8'h02:                      kind_of = FK_PROG;
      8'h03:                      kind_of = FK_READ;
      8'h0B:                      kind_of = FK_FREAD;
      8'h05:                      kind_of = FK_RSTAT;
      8'h9F:                      kind_of = FK_IDENT;
      8'h90:                      kind_of = FK_MDID;
      default:                    kind_of = FK_UNKNOWN;
    endcase
  endfunction

  // bytes before the output or write-data phase
  function automatic logic [2:0] hdr_len(input fkind_e k);
    case (k)
      FK_ERASE, FK_PROG, FK_READ, FK_MDID: hdr_len = 3'd4;
      FK_FREAD:                            hdr_len = 3'd5;
      default:                             hdr_len = 3'd1;
    endcase
  endfunction

  // bytes a frame needs to be valid
  function automatic logic [2:0] min_len(input fkind_e k);
    case (k)
      FK_WSTAT: min_len = 3'd2;
      FK_PROG:  min_len = 3'd5;
      default:  min_len = hdr_len(k);
    endcase
  endfunction

  function automatic logic exact_len(input fkind_e k);
    exact_len = (k == FK_CTRL) || (k == FK_ERASE) || (k == FK_WSTAT);
  endfunction

  function automatic logic is_writer(input fkind_e k);
    is_writer = (k == FK_CTRL) || (k == FK_ERASE) || (k == FK_WSTAT) || (k == FK_PROG);
  endfunction

  function automatic logic is_reader(input fkind_e k);
    is_reader = (k == FK_READ) || (k == FK_FREAD) || (k == FK_RSTAT) ||
                (k == FK_IDENT) || (k == FK_MDID);
  endfunction

  function automatic logic busy_gated(input fkind_e k);
    busy_gated = (k == FK_READ) || (k == FK_FREAD) || (k == FK_IDENT);
  endfunction

  function automatic logic has_wdata(input fkind_e k);
    has_wdata = (k == FK_WSTAT) || (k == FK_PROG);
  endfunction

endpackage

// File: rtl/fe_rx_shift.sv
module fe_rx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       si,
  output logic       fall_o,
  output logic       cs_end_o,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic [2:0] byte_idx_o,
  output logic [2:0] bit_cnt_o,
  output logic [2:0] byte_cnt_o
);
  localparam logic [2:0] BYTE_SAT = 3'd7;

  logic       sclk_q, cs_q;
  logic [2:0] bitc_q, bitc_d;
  logic [2:0] bytec_q, bytec_d;
  logic [6:0] sh_q, sh_d;
  logic       rise;

  assign rise        = ~cs_n & sclk & ~sclk_q;
  assign fall_o      = ~cs_n & ~sclk & sclk_q;
  assign cs_end_o    = cs_n & ~cs_q;
  assign byte_done_o = rise & (bitc_q == 3'd7);
  assign byte_o      = {sh_q, si};
  assign byte_idx_o  = bytec_q;
  assign bit_cnt_o   = bitc_q;
  assign byte_cnt_o  = bytec_q;

  always_comb begin
    bitc_d  = bitc_q;
    bytec_d = bytec_q;
    sh_d    = sh_q;
    if (cs_n) begin
      bitc_d  = 3'd0;
      bytec_d = 3'd0;
    end else if (rise) begin
      sh_d   = {sh_q[5:0], si};
      bitc_d = bitc_q + 3'd1;
      if (bitc_q == 3'd7 && bytec_q != BYTE_SAT) bytec_d = bytec_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      bitc_q  <= 3'd0;
      bytec_q <= 3'd0;
      sh_q    <= 7'd0;
    end else begin
      sclk_q  <= sclk;
      cs_q    <= cs_n;
      bitc_q  <= bitc_d;
      bytec_q <= bytec_d;
      sh_q    <= sh_d;
    end
  end

  // a byte index only advances after the eighth rising edge of a byte
  assert_byte_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bytec_q != $past(bytec_q)) && !$past(cs_n) |-> $past(byte_done_o));

endmodule

// File: rtl/fe_tx_path.sv
module fe_tx_path
  import flash_fe_pkg::*;
#(
  parameter int          ADDR_W  = 19,
  parameter logic [7:0]  MFR_ID  = 8'h0E,
  parameter logic [7:0]  TYPE_ID = 8'h40,
  parameter logic [7:0]  CAP_ID  = 8'h13,
  parameter logic [7:0]  DEV_ID  = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              fall,
  input  logic              load,
  input  fkind_e            kind,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        status,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_req,
  output logic              so,
  output logic              so_oe
);
  logic [7:0]        sr_q, sr_d;
  logic              so_q, so_d;
  logic              oe_q, oe_d;
  logic              live_q, live_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [1:0]        id_q, id_d, cur_id;
  logic [7:0]        src;

  assign rd_addr = live_q ? ptr_q : start_addr;
  assign cur_id  = live_q ? id_q : ((kind == FK_MDID) ? {1'b0, start_addr[0]} : 2'd0);
  assign rd_req  = load & ((kind == FK_READ) || (kind == FK_FREAD));
  assign so      = so_q;
  assign so_oe   = oe_q & ~cs_n;

  always_comb begin
    case (kind)
      FK_READ, FK_FREAD: src = rd_data;
      FK_RSTAT:          src = status;
      FK_IDENT:          src = (cur_id == 2'd0) ? MFR_ID : (cur_id == 2'd1) ? TYPE_ID : CAP_ID;
      FK_MDID:           src = cur_id[0] ? DEV_ID : MFR_ID;
      default:           src = 8'h00;
    endcase
  end

  always_comb begin
    sr_d   = sr_q;
    so_d   = so_q;
    oe_d   = oe_q;
    live_d = live_q;
    ptr_d  = ptr_q;
    id_d   = id_q;
    if (cs_n) begin
      oe_d   = 1'b0;
      live_d = 1'b0;
    end else if (load) begin
      sr_d   = src;
      live_d = 1'b1;
      ptr_d  = rd_addr + 1'b1;
      if (kind == FK_IDENT) id_d = (cur_id == 2'd2) ? 2'd0 : cur_id + 2'd1;
      else                  id_d = {1'b0, ~cur_id[0]};
    end else if (fall && live_q) begin
      so_d = sr_q[7];
      sr_d = {sr_q[6:0], 1'b0};
      oe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= 8'h00;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
      live_q <= 1'b0;
      ptr_q  <= '0;
      id_q   <= 2'd0;
    end else begin
      sr_q   <= sr_d;
      so_q   <= so_d;
      oe_q   <= oe_d;
      live_q <= live_d;
      ptr_q  <= ptr_d;
      id_q   <= id_d;
    end
  end

  assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(fall));

  assert_so_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe && $past(so_oe) && !$past(fall) |-> $stable(so));

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int          ADDR_W  = 19,
  parameter logic [7:0]  MFR_ID  = 8'h0E,
  parameter logic [7:0]  TYPE_ID = 8'h40,
  parameter logic [7:0]  CAP_ID  = 8'h13,
  parameter logic [7:0]  DEV_ID  = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              busy,
  input  logic [7:0]        status,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_req,
  input  logic [7:0]        rd_data,
  output logic              cmd_valid,
  output logic [7:0]        cmd_op,
  output logic [23:0]       cmd_addr,
  output logic              cmd_aligned,
  output logic              cmd_ok,
  output logic              din_valid,
  output logic [7:0]        din_byte
);
  logic       fall, cs_end, byte_done;
  logic [7:0] byte_val;
  logic [2:0] byte_idx, bit_cnt, byte_cnt;

  fe_rx_shift i_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .fall_o(fall), .cs_end_o(cs_end), .byte_done_o(byte_done),
    .byte_o(byte_val), .byte_idx_o(byte_idx), .bit_cnt_o(bit_cnt),
    .byte_cnt_o(byte_cnt)
  );

  fkind_e      kind_q, kind_d, kind_now;
  logic [23:0] addr_q, addr_d;
  logic        mute_q, mute_d, mute_now;
  logic        load_q, load_d;
  logic        cv_d, cal_d, cok_d, dv_d;
  logic [7:0]  cop_d, db_d;
  logic [23:0] caddr_d;
  logic [3:0]  next_idx;
  logic [2:0]  need;
  logic        len_ok, aligned_now;

  assign kind_now    = (byte_idx == 3'd0) ? kind_of(byte_val) : kind_q;
  assign mute_now    = (byte_idx == 3'd0) ? (busy & busy_gated(kind_now)) : mute_q;
  assign next_idx    = {1'b0, byte_idx} + 4'd1;
  assign need        = min_len(kind_q);
  assign len_ok      = exact_len(kind_q) ? (byte_cnt == need) : (byte_cnt >= need);
  assign aligned_now = (bit_cnt == 3'd0);

  always_comb begin
    kind_d  = kind_q;
    addr_d  = addr_q;
    mute_d  = mute_q;
    load_d  = 1'b0;
    cv_d    = 1'b0;
    cop_d   = cmd_op;
    caddr_d = cmd_addr;
    cal_d   = cmd_aligned;
    cok_d   = cmd_ok;
    dv_d    = 1'b0;
    db_d    = din_byte;
    if (cs_n) begin
      mute_d = 1'b0;
      addr_d = 24'h0;
      if (cs_end && byte_cnt != 3'd0) begin
        cv_d    = 1'b1;
        caddr_d = addr_q;
        cal_d   = aligned_now;
        cok_d   = (kind_q != FK_UNKNOWN) && len_ok && (!is_writer(kind_q) || aligned_now);
      end
    end else if (byte_done) begin
      if (byte_idx == 3'd0) begin
        cop_d  = byte_val;
        kind_d = kind_now;
        mute_d = mute_now;
      end else if (byte_idx <= 3'd3) begin
        addr_d = {addr_q[15:0], byte_val};
      end
      if (is_reader(kind_now) && !mute_now && next_idx >= {1'b0, hdr_len(kind_now)})
        load_d = 1'b1;
      if (byte_idx != 3'd0 && has_wdata(kind_q) && byte_idx >= hdr_len(kind_q)) begin
        dv_d = 1'b1;
        db_d = byte_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q      <= FK_UNKNOWN;
      addr_q      <= 24'h0;
      mute_q      <= 1'b0;
      load_q      <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_op      <= 8'h00;
      cmd_addr    <= 24'h0;
      cmd_aligned <= 1'b0;
      cmd_ok      <= 1'b0;
      din_valid   <= 1'b0;
      din_byte    <= 8'h00;
    end else begin
      kind_q      <= kind_d;
      addr_q      <= addr_d;
      mute_q      <= mute_d;
      load_q      <= load_d;
      cmd_valid   <= cv_d;
      cmd_op      <= cop_d;
      cmd_addr    <= caddr_d;
      cmd_aligned <= cal_d;
      cmd_ok      <= cok_d;
      din_valid   <= dv_d;
      din_byte    <= db_d;
    end
  end

  fe_tx_path #(
    .ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .TYPE_ID(TYPE_ID),
    .CAP_ID(CAP_ID), .DEV_ID(DEV_ID)
  ) i_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(fall), .load(load_q),
    .kind(kind_q), .start_addr(addr_q[ADDR_W-1:0]), .status(status),
    .rd_data(rd_data), .rd_addr(rd_addr), .rd_req(rd_req),
    .so(so), .so_oe(so_oe)
  );

  assert_report_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_report_after_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_n) && !$past(cs_n, 2));

  assert_busy_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q && !cs_n |-> !so_oe);

  assert_din_class_R11: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid |-> (kind_q == FK_WSTAT) || (kind_q == FK_PROG));

  assert_writer_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_aligned && is_writer(kind_q) |-> !cmd_ok);

endmodule

// File: tb/test_flash_cmd_frontend.sv
module test_flash_cmd_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int ADDR_W     = 19;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, si, busy;
  logic [7:0] status, rd_data;
  logic so, so_oe, rd_req, cmd_valid, cmd_aligned, cmd_ok, din_valid;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] cmd_op, din_byte;
  logic [23:0] cmd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_frontend #(.ADDR_W(ADDR_W)) i_flash_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .busy(busy), .status(status),
    .rd_addr(rd_addr), .rd_req(rd_req), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_aligned(cmd_aligned), .cmd_ok(cmd_ok),
    .din_valid(din_valid), .din_byte(din_byte)
  );

  function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
    mem_byte = a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]};
  endfunction
  assign rd_data = mem_byte(rd_addr);

  int total = 0, fails = 0;
  int cmd_cnt = 0, din_cnt = 0;
  logic [7:0] din_last;
  logic [7:0] rec_op;
  logic [23:0] rec_addr;
  logic rec_al, rec_ok;

  always @(negedge clk) begin
    if (cmd_valid) begin
      cmd_cnt++; rec_op = cmd_op; rec_addr = cmd_addr; rec_al = cmd_aligned; rec_ok = cmd_ok;
    end
    if (din_valid) begin
      din_cnt++; din_last = din_byte;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_tx(input logic m3);
    @(negedge clk); sclk = m3;
    wait_n(2); cs_n = 1'b0; wait_n(2);
  endtask

  task automatic end_tx(input logic m3);
    wait_n(HALF);
    if (!m3) sclk = 1'b0;
    wait_n(HALF); cs_n = 1'b1;
    wait_n(8);
    sclk = m3;
  endtask

  task automatic xfer_n(input logic [7:0] tx, input int n, output logic [7:0] rx, output logic oe);
    rx = 8'h00; oe = 1'b0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; si = tx[7-i];
      wait_n(HALF);
      sclk = 1'b1;
      rx[7-i] = so; oe = oe | so_oe;
      wait_n(HALF);
    end
  endtask

  task automatic frame(input logic m3, input logic [63:0] s, input int nbytes, input int xbits);
    logic [7:0] r; logic o;
    begin_tx(m3);
    for (int i = 0; i < nbytes; i++) xfer_n(s[63-8*i -: 8], 8, r, o);
    if (xbits > 0) xfer_n(8'hFF, xbits, r, o);
    end_tx(m3);
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic        m3;
    logic        bsy;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h03, 24'h000010, 1'b0, 1'b0, 24'h101112},
    '{8'h0B, 24'h012345, 1'b1, 1'b0, 24'h676465},
    '{8'h03, 24'hFFFFFF, 1'b0, 1'b0, 24'h070001},
    '{8'h05, 24'h000000, 1'b1, 1'b1, 24'hA5A5A5},
    '{8'h9F, 24'h000000, 1'b1, 1'b0, 24'h0E4013},
    '{8'h90, 24'h000000, 1'b0, 1'b0, 24'h0E120E},
    '{8'h90, 24'h000001, 1'b1, 1'b0, 24'h120E12},
    '{8'h03, 24'h000100, 1'b1, 1'b1, 24'h000000},
    '{8'h9F, 24'h000000, 1'b0, 1'b1, 24'h000000}
  };

  task automatic run_vec(input vec_t v);
    logic [7:0] r; logic o, hoe, doe, gated; logic [23:0] got; int c0;
    string tag;
    busy = v.bsy; c0 = cmd_cnt; hoe = 1'b0; doe = 1'b0; got = 24'h0;
    begin_tx(v.m3);
    xfer_n(v.op, 8, r, o); hoe |= o;
    if (v.op == 8'h03 || v.op == 8'h0B || v.op == 8'h90) begin
      xfer_n(v.addr[23:16], 8, r, o); hoe |= o;
      xfer_n(v.addr[15:8], 8, r, o);  hoe |= o;
      xfer_n(v.addr[7:0], 8, r, o);   hoe |= o;
    end
    if (v.op == 8'h0B) begin xfer_n(8'h00, 8, r, o); hoe |= o; end
    for (int k = 0; k < 3; k++) begin
      xfer_n(8'h00, 8, r, o); got = {got[15:0], r}; doe |= o;
    end
    end_tx(v.m3);
    busy = 1'b0;
    chk("R10 output enable in header", {31'b0, hoe}, 32'd0);
    gated = v.bsy && (v.op == 8'h03 || v.op == 8'h0B || v.op == 8'h9F);
    case (v.op)
      8'h03: tag = "R4 read stream";
      8'h0B: tag = "R5 fast read stream";
      8'h05: tag = "R6 status stream";
      8'h9F: tag = "R7 ident stream";
      default: tag = "R8 maker/device stream";
    endcase
    if (v.m3) tag = {tag, " (R1 mode 3)"};
    if (gated) chk("R9 output enable while busy", {31'b0, doe}, 32'd0);
    else       chk(tag, {8'h0, got}, {8'h0, v.exp});
    chk("R2 record count", cmd_cnt - c0, 32'd1);
    chk("R2 record opcode", {24'h0, rec_op}, {24'h0, v.op});
    chk("R2 record ok", {31'b0, rec_ok}, 32'd1);
  endtask

  task automatic check_frame(input string req, input logic m3, input logic [63:0] s,
                             input int nb, input int xb, input logic exp_al, input logic exp_ok);
    int c0;
    c0 = cmd_cnt;
    frame(m3, s, nb, xb);
    chk({req, " record count"}, cmd_cnt - c0, 32'd1);
    chk({req, " aligned"}, {31'b0, rec_al}, {31'b0, exp_al});
    chk({req, " ok"}, {31'b0, rec_ok}, {31'b0, exp_ok});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] r; logic o; int d0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; si = 1'b0; busy = 1'b0; status = 8'hA5;
    wait_n(5);
    chk("R10 reset so_oe", {31'b0, so_oe}, 32'd0);
    chk("R2 reset cmd_valid", {31'b0, cmd_valid}, 32'd0);
    chk("R11 reset din_valid", {31'b0, din_valid}, 32'd0);
    rst_n = 1'b1;
    wait_n(4);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // write-class framing
    check_frame("R3 wren exact", 1'b0, {8'h06, 56'h0}, 1, 0, 1'b1, 1'b1);
    check_frame("R3 wren stray bits", 1'b1, {8'h06, 56'h0}, 1, 3, 1'b0, 1'b0);
    check_frame("R2 sector erase", 1'b0, {8'h20, 24'h0A1B2C, 32'h0}, 4, 0, 1'b1, 1'b1);
    chk("R2 record address", {8'h0, rec_addr}, 32'h000A1B2C);
    check_frame("R3 erase short", 1'b0, {8'h20, 24'h0A1B00, 32'h0}, 3, 0, 1'b1, 1'b0);
    check_frame("R3 block erase long", 1'b1, {8'hD8, 24'h010000, 8'h00, 24'h0}, 5, 0, 1'b1, 1'b0);
    check_frame("R3 chip erase C7", 1'b0, {8'hC7, 56'h0}, 1, 0, 1'b1, 1'b1);
    check_frame("R3 chip erase 60", 1'b1, {8'h60, 56'h0}, 1, 0, 1'b1, 1'b1);
    check_frame("R3 unknown opcode", 1'b0, {8'hFF, 56'h0}, 1, 0, 1'b1, 1'b0);

    d0 = din_cnt;
    check_frame("R11 status write", 1'b1, {8'h01, 8'h1C, 48'h0}, 2, 0, 1'b1, 1'b1);
    chk("R11 status write bytes", din_cnt - d0, 32'd1);
    chk("R11 status write data", {24'h0, din_last}, 32'h1C);

    d0 = din_cnt;
    check_frame("R11 page program", 1'b0, {8'h02, 24'h000100, 24'hAABBCC, 8'h0}, 7, 0, 1'b1, 1'b1);
    chk("R11 program bytes", din_cnt - d0, 32'd3);
    chk("R11 program last byte", {24'h0, din_last}, 32'hCC);

    d0 = din_cnt;
    check_frame("R3 program header only", 1'b0, {8'h02, 24'h000100, 32'h0}, 4, 0, 1'b1, 1'b0);
    chk("R11 header-only program bytes", din_cnt - d0, 32'd0);

    // read cut off mid-bit, then a fresh command
    begin_tx(1'b0);
    xfer_n(8'h03, 8, r, o); xfer_n(8'h00, 8, r, o); xfer_n(8'h00, 8, r, o);
    xfer_n(8'h20, 8, r, o); xfer_n(8'h00, 3, r, o);
    end_tx(1'b0);
    chk("R12 cut read aligned", {31'b0, rec_al}, 32'd0);
    chk("R12 cut read ok", {31'b0, rec_ok}, 32'd1);
    chk("R12 cut read first bits", {29'b0, r[7:5]}, {29'b0, mem_byte(19'h20) >> 5});

    begin_tx(1'b1);
    xfer_n(8'h9F, 8, r, o);
    xfer_n(8'h00, 8, r, o);
    chk("R12 fresh opcode after cut", {24'h0, r}, 32'h0E);
    xfer_n(8'h00, 8, r, o); xfer_n(8'h00, 8, r, o); xfer_n(8'h00, 8, r, o);
    chk("R7 ident repeats", {24'h0, r}, 32'h0E);
    end_tx(1'b1);

    status = 8'h3C; busy = 1'b1;
    begin_tx(1'b1);
    xfer_n(8'h05, 8, r, o); xfer_n(8'h00, 8, r, o);
    end_tx(1'b1);
    busy = 1'b0;
    chk("R6 R1 status in mode 3 while busy", {24'h0, r}, 32'h3C);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule